// File: doc/BRIEF.md
# Load-Use Hazard Interlock

This block sits beside the decode stage of an in-order pipeline and keeps an instruction from reading a register that a recent load has not yet delivered. It tracks every load that leaves decode for three cycles and compares each load's destination with the source registers of the instruction now in decode. When a dependency is still too close, it raises a stall. The stall holds decode in place and puts a bubble into execute.

A single configuration input picks how load data reaches a consumer. With direct forwarding on, the returning data can drive the operand path in the same cycle it arrives. With it off, the data is first captured in a holding register and is usable one cycle later. The block contains that holding register. For each source port it drives an operand selected from the register file, the live load data or the held load data, and it reports that choice on a select output.

Timing model: a load leaves decode at the clock edge that ends its decode cycle. Its age is 1 in the next cycle, 2 in the one after, and so on. Its data is on `ld_rdata` during age 2. From age 4 on, the register file holds the value.

Top module: `lu_interlock`

## Requirements
- R1: After reset no load is tracked. `stall` is 0 and every `byp_sel` is 2'b00 (register file), even if decode presents a source that matches some register.
- R2: `stall` is asserted only when `dec_valid` is 1 and a tracked, valid load's destination equals a source register whose use bit is 1. A cycle with `dec_valid` low never stalls.
- R3: With `fwd_en`=1, a consumer directly behind a load stalls for exactly one cycle. In the next cycle it gets `byp_sel`=2'b01, and its operand equals `ld_rdata` in that same cycle.
- R4: With `fwd_en`=0, a consumer directly behind a load stalls for exactly two cycles. It then gets `byp_sel`=2'b10, and its operand is the value `ld_rdata` carried during the load's age-2 cycle, whatever `ld_rdata` shows now.
- R5: With `fwd_en`=0 and one independent instruction between load and consumer, the consumer stalls for exactly one cycle and then reads the held value.
- R6: With two independent instructions between load and consumer, there is no stall and the select is 2'b10 in either mode. With three or more, the select is 2'b00 and the operand is `rf_rdata`.
- R7: An instruction that reads no register written by a tracked load never stalls, even in the cycle right after a load.
- R8: Every source port is compared. A match on port 1 alone stalls. A port whose use bit is 0 never causes a stall, even when its register matches.
- R9: A stalled cycle takes no instruction out of decode. A load held in decode is not tracked until the cycle in which it issues, and the check is repeated on each stalled cycle.
- R10: When several tracked loads write the same register, the youngest decides the stall and the select.
- R11: `byp_sel` never takes the value 2'b11. It shows 2'b01 only while `fwd_en` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| fwd_en | input | 1 | 1: load data forwarded directly; 0: via holding register |
| dec_valid | input | 1 | Decode stage holds an instruction |
| dec_is_load | input | 1 | Instruction in decode is a load |
| dec_dst | input | RW | Destination register of the load in decode |
| dec_src | input | NSRC*RW | Source register of each port |
| dec_src_use | input | NSRC | Port reads its source register |
| rf_rdata | input | NSRC*DW | Register file value per port |
| ld_rdata | input | DW | Load data, valid during the load's age-2 cycle |
| stall | output | 1 | Hold decode, bubble into execute |
| byp_sel | output | NSRC*2 | Per port: 00 register file, 01 live load data, 10 held load data |
| opnd | output | NSRC*DW | Selected operand per port |

## Verification
The bench places a consumer at distance one, two, three and four behind a load, in both forwarding modes, and counts the stall cycles. A design that ignored the mode or miscounted ages would stall too often or too little, or would hand the consumer stale data. In the no-forwarding cases `ld_rdata` changes after the capture cycle, so a design that skips the holding register shows the wrong operand. Other tests put two loads to the same register back to back, create a dependency on the second port only, and present a matching register on a port marked unused. These expose a design that lets an older load win, compares only one port, or ignores the use bits.

// File: rtl/lu_pkg.sv
package lu_pkg;

    // Number of load ages tracked. Loads older than this are in the register file.
    localparam int LU_AGES = 3;

    // Operand source per port.
    typedef enum logic [1:0] {
        SEL_RF   = 2'b00,
        SEL_FWD  = 2'b01,
        SEL_HOLD = 2'b10
    } byp_sel_e;

    // Decision for one source port.
    typedef struct packed {
        logic     stall;
        byp_sel_e sel;
    } lu_dec_t;

    // hit[0] is age 1 (youngest). The youngest match decides.
    function automatic lu_dec_t lu_resolve(input logic [LU_AGES-1:0] hit,
                                           input logic fwd);
        lu_dec_t d;
        d.stall = 1'b0;
        d.sel   = SEL_RF;
        if (hit[0]) begin
            d.stall = 1'b1;
        end else if (hit[1]) begin
            if (fwd) d.sel   = SEL_FWD;
            else     d.stall = 1'b1;
        end else if (hit[2]) begin
            d.sel = SEL_HOLD;
        end
        return d;
    endfunction

endpackage

// File: rtl/lu_tracker.sv
module lu_tracker
    import lu_pkg::*;
#(
    parameter int RW = 5
) (
    input  logic                       clk,
    input  logic                       rst,
    input  logic                       push,
    input  logic [RW-1:0]              push_dst,
    output logic [LU_AGES-1:0]         trk_valid,
    output logic [LU_AGES-1:0][RW-1:0] trk_dst
);

    // Stage 0 takes an issuing load; a stall pushes a bubble.
    always_ff @(posedge clk) begin
        if (rst) begin
            trk_valid[0] <= 1'b0;
            trk_dst[0]   <= '0;
        end else begin
            trk_valid[0] <= push;
            trk_dst[0]   <= push_dst;
        end
    end

    // Later stages age by one every cycle, stalled or not.
    for (genvar i = 1; i < LU_AGES; i++) begin : g_age
        always_ff @(posedge clk) begin
            if (rst) begin
                trk_valid[i] <= 1'b0;
                trk_dst[i]   <= '0;
            end else begin
                trk_valid[i] <= trk_valid[i-1];
                trk_dst[i]   <= trk_dst[i-1];
            end
        end
    end

endmodule

// File: rtl/lu_src_match.sv
module lu_src_match
    import lu_pkg::*;
#(
    parameter int RW = 5
) (
    input  logic [RW-1:0]              src,
    input  logic                       src_use,
    input  logic [LU_AGES-1:0]         trk_valid,
    input  logic [LU_AGES-1:0][RW-1:0] trk_dst,
    output logic [LU_AGES-1:0]         age_hit
);

    for (genvar a = 0; a < LU_AGES; a++) begin : g_cmp
        assign age_hit[a] = src_use && trk_valid[a] && (trk_dst[a] == src);
    end

endmodule

// File: rtl/lu_operand_path.sv
module lu_operand_path
    import lu_pkg::*;
#(
    parameter int NSRC = 2,
    parameter int DW   = 32
) (
    input  logic                     clk,
    input  logic                     rst,
    input  logic                     capture,
    input  logic [DW-1:0]            ld_rdata,
    input  logic [NSRC-1:0][DW-1:0]  rf_rdata,
    input  byp_sel_e                 sel [NSRC],
    output logic [NSRC-1:0][DW-1:0]  opnd
);

    logic [DW-1:0] hold_q;

    // Holding register: load data one cycle after it returns.
    always_ff @(posedge clk) begin
        if (rst)          hold_q <= '0;
        else if (capture) hold_q <= ld_rdata;
    end

    for (genvar p = 0; p < NSRC; p++) begin : g_mux
        always_comb begin
            unique case (sel[p])
                SEL_FWD:  opnd[p] = ld_rdata;
                SEL_HOLD: opnd[p] = hold_q;
                default:  opnd[p] = rf_rdata[p];
            endcase
        end
    end

endmodule

// File: rtl/lu_interlock.sv
module lu_interlock
    import lu_pkg::*;
#(
    parameter int NSRC = 2,
    parameter int RW   = 5,
    parameter int DW   = 32
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    fwd_en,
    input  logic                    dec_valid,
    input  logic                    dec_is_load,
    input  logic [RW-1:0]           dec_dst,
    input  logic [NSRC-1:0][RW-1:0] dec_src,
    input  logic [NSRC-1:0]         dec_src_use,
    input  logic [NSRC-1:0][DW-1:0] rf_rdata,
    input  logic [DW-1:0]           ld_rdata,
    output logic                    stall,
    output logic [NSRC-1:0][1:0]    byp_sel,
    output logic [NSRC-1:0][DW-1:0] opnd
);

    localparam int DATA_AGE_IDX = 1;

    logic [LU_AGES-1:0]         trk_valid;
    logic [LU_AGES-1:0][RW-1:0] trk_dst;
    logic [NSRC-1:0]            port_stall;
    byp_sel_e                   port_sel [NSRC];
    logic                       push;

    // A load enters tracking only in the cycle it actually issues.
    assign push = dec_valid && dec_is_load && !stall;

    lu_tracker #(.RW(RW)) u_trk (
        .clk       (clk),
        .rst       (rst),
        .push      (push),
        .push_dst  (dec_dst),
        .trk_valid (trk_valid),
        .trk_dst   (trk_dst)
    );

    for (genvar p = 0; p < NSRC; p++) begin : g_port
        logic [LU_AGES-1:0] hit;
        lu_dec_t            dec;

        lu_src_match #(.RW(RW)) u_match (
            .src       (dec_src[p]),
            .src_use   (dec_src_use[p]),
            .trk_valid (trk_valid),
            .trk_dst   (trk_dst),
            .age_hit   (hit)
        );

        assign dec           = lu_resolve(hit, fwd_en);
        assign port_stall[p] = dec.stall;
        assign port_sel[p]   = dec.sel;
        assign byp_sel[p]    = dec.sel;
    end

    assign stall = dec_valid && (|port_stall);

    lu_operand_path #(.NSRC(NSRC), .DW(DW)) u_opnd (
        .clk      (clk),
        .rst      (rst),
        .capture  (trk_valid[DATA_AGE_IDX]),
        .ld_rdata (ld_rdata),
        .rf_rdata (rf_rdata),
        .sel      (port_sel),
        .opnd     (opnd)
    );

endmodule

// File: rtl/lu_interlock_chk.sv
module lu_interlock_chk
    import lu_pkg::*;
#(
    parameter int NSRC = 2
) (
    input logic                 clk,
    input logic                 rst,
    input logic                 fwd_en,
    input logic                 dec_valid,
    input logic                 stall,
    input logic [NSRC-1:0][1:0] byp_sel,
    input logic [LU_AGES-1:0]   trk_valid
);

    a_r2_stall_needs_valid: assert property (@(posedge clk) disable iff (rst)
        stall |-> dec_valid);

    a_r3_single_stall: assert property (@(posedge clk) disable iff (rst)
        (fwd_en && $past(fwd_en) && $past(stall)) |-> !stall);

    a_r4_two_stall_max: assert property (@(posedge clk) disable iff (rst)
        (!fwd_en && !$past(fwd_en) && !$past(fwd_en, 2) &&
         $past(stall) && $past(stall, 2)) |-> !stall);

    a_r9_bubble: assert property (@(posedge clk) disable iff (rst)
        stall |=> !trk_valid[0]);

    for (genvar p = 0; p < NSRC; p++) begin : g_sel
        a_r11_fwd_only_in_mode: assert property (@(posedge clk) disable iff (rst)
            (byp_sel[p] == 2'b01) |-> fwd_en);
        a_r11_no_bad_code: assert property (@(posedge clk) disable iff (rst)
            byp_sel[p] != 2'b11);
    end

endmodule

bind lu_interlock lu_interlock_chk #(.NSRC(NSRC)) u_chk (
    .clk       (clk),
    .rst       (rst),
    .fwd_en    (fwd_en),
    .dec_valid (dec_valid),
    .stall     (stall),
    .byp_sel   (byp_sel),
    .trk_valid (trk_valid)
);

// File: tb/lu_interlock_bench.sv
module lu_interlock_bench;

    localparam int NSRC = 2;
    localparam int RW   = 5;
    localparam int DW   = 32;
    localparam logic [DW-1:0] RF0 = 32'h1111_0000;
    localparam logic [DW-1:0] RF1 = 32'h2222_0000;

    logic                    clk = 1'b0;
    logic                    rst = 1'b1;
    logic                    fwd_en = 1'b1;
    logic                    dec_valid = 1'b0;
    logic                    dec_is_load = 1'b0;
    logic [RW-1:0]           dec_dst = '0;
    logic [NSRC-1:0][RW-1:0] dec_src = '0;
    logic [NSRC-1:0]         dec_src_use = '0;
    logic [NSRC-1:0][DW-1:0] rf_rdata;
    logic [DW-1:0]           ld_rdata = '0;
    logic                    stall;
    logic [NSRC-1:0][1:0]    byp_sel;
    logic [NSRC-1:0][DW-1:0] opnd;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    assign rf_rdata[0] = RF0;
    assign rf_rdata[1] = RF1;

    lu_interlock #(.NSRC(NSRC), .RW(RW), .DW(DW)) u_lu_interlock (
        .clk(clk), .rst(rst), .fwd_en(fwd_en), .dec_valid(dec_valid),
        .dec_is_load(dec_is_load), .dec_dst(dec_dst), .dec_src(dec_src),
        .dec_src_use(dec_src_use), .rf_rdata(rf_rdata), .ld_rdata(ld_rdata),
        .stall(stall), .byp_sel(byp_sel), .opnd(opnd)
    );

    task automatic check(input string req, input logic [DW-1:0] act,
                         input logic [DW-1:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Drive one decode cycle at the falling edge; outputs settle 1 ns later.
    task automatic step(input logic v, input logic ld, input logic [RW-1:0] dst,
                        input logic [RW-1:0] s0, input logic [RW-1:0] s1,
                        input logic [1:0] use_b, input logic [DW-1:0] ldata);
        @(negedge clk);
        dec_valid   = v;
        dec_is_load = ld;
        dec_dst     = dst;
        dec_src[0]  = s0;
        dec_src[1]  = s1;
        dec_src_use = use_b;
        ld_rdata    = ldata;
        #1;
    endtask

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b0, 5'd0, 5'd0, 5'd0, 2'b00, '0);
    endtask

    task automatic t_reset;
        rst = 1'b1;
        idle(3);
        dec_valid = 1'b1; dec_src[0] = 5'd0; dec_src_use = 2'b11; #1;
        check("R1 stall after reset", {31'd0, stall}, 32'd0);
        check("R1 sel after reset", {28'd0, byp_sel}, 32'd0);
        @(negedge clk); rst = 1'b0;
        idle(1);
    endtask

    task automatic t_fwd_adjacent;
        fwd_en = 1'b1;
        step(1, 1, 5'd5, 5'd1, 5'd2, 2'b11, '0);
        check("R3 load issues", {31'd0, stall}, 32'd0);
        step(1, 0, 5'd0, 5'd5, 5'd2, 2'b11, '0);
        check("R3 first stall", {31'd0, stall}, 32'd1);
        step(1, 0, 5'd0, 5'd5, 5'd2, 2'b11, 32'hBEEF_0001);
        check("R3 stall ends", {31'd0, stall}, 32'd0);
        check("R3 sel fwd", {30'd0, byp_sel[0]}, 32'd1);
        check("R3 operand fwd", opnd[0], 32'hBEEF_0001);
        check("R3 port1 from rf", opnd[1], RF1);
        idle(4);
    endtask

    task automatic t_nofwd_adjacent;
        fwd_en = 1'b0;
        step(1, 1, 5'd6, 5'd1, 5'd2, 2'b11, '0);
        step(1, 0, 5'd0, 5'd6, 5'd2, 2'b01, '0);
        check("R4 stall 1", {31'd0, stall}, 32'd1);
        step(1, 0, 5'd0, 5'd6, 5'd2, 2'b01, 32'hCAFE_0002);
        check("R4 stall 2", {31'd0, stall}, 32'd1);
        step(1, 0, 5'd0, 5'd6, 5'd2, 2'b01, 32'hDEAD_0003);
        check("R4 released", {31'd0, stall}, 32'd0);
        check("R4 sel hold", {30'd0, byp_sel[0]}, 32'd2);
        check("R4 held operand", opnd[0], 32'hCAFE_0002);
        idle(4);
    endtask

    task automatic t_nofwd_gap1;
        fwd_en = 1'b0;
        step(1, 1, 5'd7, 5'd1, 5'd2, 2'b11, '0);
        step(1, 0, 5'd0, 5'd3, 5'd4, 2'b11, '0);
        check("R5 independent between", {31'd0, stall}, 32'd0);
        step(1, 0, 5'd0, 5'd7, 5'd2, 2'b01, 32'h0000_0A0A);
        check("R5 one stall", {31'd0, stall}, 32'd1);
        step(1, 0, 5'd0, 5'd7, 5'd2, 2'b01, 32'h0000_0B0B);
        check("R5 released", {31'd0, stall}, 32'd0);
        check("R5 held operand", opnd[0], 32'h0000_0A0A);
        idle(4);
    endtask

    task automatic t_gap2_gap3;
        fwd_en = 1'b0;
        step(1, 1, 5'd8, 5'd1, 5'd2, 2'b11, '0);
        step(1, 0, 5'd0, 5'd3, 5'd4, 2'b11, '0);
        step(1, 0, 5'd0, 5'd3, 5'd4, 2'b11, 32'h1234_5678);
        step(1, 0, 5'd0, 5'd8, 5'd2, 2'b01, 32'h0);
        check("R6 gap2 no stall", {31'd0, stall}, 32'd0);
        check("R6 gap2 sel hold", {30'd0, byp_sel[0]}, 32'd2);
        check("R6 gap2 operand", opnd[0], 32'h1234_5678);
        idle(4);
        fwd_en = 1'b1;
        step(1, 1, 5'd9, 5'd1, 5'd2, 2'b11, '0);
        step(1, 0, 5'd0, 5'd3, 5'd4, 2'b11, '0);
        step(1, 0, 5'd0, 5'd3, 5'd4, 2'b11, 32'h5555_0000);
        step(1, 0, 5'd0, 5'd3, 5'd4, 2'b11, '0);
        step(1, 0, 5'd0, 5'd9, 5'd2, 2'b01, '0);
        check("R6 gap3 no stall", {31'd0, stall}, 32'd0);
        check("R6 gap3 sel rf", {30'd0, byp_sel[0]}, 32'd0);
        check("R6 gap3 operand rf", opnd[0], RF0);
        idle(4);
    endtask

    task automatic t_independent;
        fwd_en = 1'b0;
        step(1, 1, 5'd10, 5'd1, 5'd2, 2'b11, '0);
        step(1, 0, 5'd0, 5'd11, 5'd12, 2'b11, '0);
        check("R7 no stall after load", {31'd0, stall}, 32'd0);
        step(1, 1, 5'd13, 5'd14, 5'd15, 2'b11, '0);
        check("R7 second load issues", {31'd0, stall}, 32'd0);
        idle(4);
    endtask

    task automatic t_ports_and_valid;
        fwd_en = 1'b1;
        step(1, 1, 5'd17, 5'd1, 5'd2, 2'b11, '0);
        step(1, 0, 5'd0, 5'd3, 5'd17, 2'b11, '0);
        check("R8 port1 dependency stalls", {31'd0, stall}, 32'd1);
        idle(4);
        step(1, 1, 5'd18, 5'd1, 5'd2, 2'b11, '0);
        step(1, 0, 5'd0, 5'd18, 5'd18, 2'b00, '0);
        check("R8 unused ports ignored", {31'd0, stall}, 32'd0);
        idle(4);
        step(1, 1, 5'd19, 5'd1, 5'd2, 2'b11, '0);
        step(0, 0, 5'd0, 5'd19, 5'd2, 2'b11, '0);
        check("R2 no stall without valid", {31'd0, stall}, 32'd0);
        idle(4);
    endtask

    task automatic t_held_load;
        // A load waiting in decode must not be tracked while stalled.
        fwd_en = 1'b0;
        step(1, 1, 5'd20, 5'd1, 5'd2, 2'b11, '0);
        step(1, 1, 5'd21, 5'd20, 5'd2, 2'b01, '0);
        check("R9 dependent load stalls", {31'd0, stall}, 32'd1);
        step(1, 0, 5'd0, 5'd21, 5'd2, 2'b01, '0);
        check("R9 stalled load not tracked", {31'd0, stall}, 32'd0);
        idle(4);
    endtask

    task automatic t_youngest;
        fwd_en = 1'b1;
        step(1, 1, 5'd3, 5'd1, 5'd2, 2'b11, '0);
        step(1, 1, 5'd3, 5'd1, 5'd2, 2'b11, 32'hAAAA_0001);
        step(1, 0, 5'd0, 5'd3, 5'd2, 2'b01, 32'hAAAA_0001);
        check("R10 youngest stalls", {31'd0, stall}, 32'd1);
        step(1, 0, 5'd0, 5'd3, 5'd2, 2'b01, 32'hBBBB_0002);
        check("R10 released", {31'd0, stall}, 32'd0);
        check("R10 youngest sel fwd", {30'd0, byp_sel[0]}, 32'd1);
        check("R10 youngest data", opnd[0], 32'hBBBB_0002);
        idle(4);
    endtask

    initial begin
        #(8 * 200000);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_fwd_adjacent();
        t_nofwd_adjacent();
        t_nofwd_gap1();
        t_gap2_gap3();
        t_independent();
        t_ports_and_valid();
        t_held_load();
        t_youngest();
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

endmodule